// File: doc/BRIEF.md
# Processor Interrupt Level Arbiter

This block sits beside a processor core and reduces every pending interrupt source to a single hard-interrupt request and the trap type that goes with it. Level sources come from a 16-bit external level vector and from a software-interrupt register. Two bits of that register report timer matches: bit 0 for the tick match and bit 16 for the system-tick match. The arbiter compares the highest pending level with the processor interrupt level (PIL) and the global enable. It also keeps a new level interrupt from pre-empting an external-interrupt trap of higher value that is already being serviced.

A separate vector-request line carries a 5-bit source number. Its rising edge latches a vector-pending status bit and three data words. While that status is set, the request is owned by the vector trap type, whatever the level inputs are doing. The falling edge releases it.

The request and trap-type outputs are registered and are recomputed on every clock. Each output reflects the inputs sampled at the previous rising edge. When nothing changes, the outputs keep their values and do not pulse again.

Top module: `irq_level_arbiter`

## Requirements
- R1: The pending set is formed as a bitwise OR of `ext_level[15:0]` and `softint[15:0]`, with `softint` bit 0 (tick match) and bit 16 (system-tick match) removed first. A software bit n in the range 1..15 therefore acts like external level n.
- R2: When `softint` bit 0 or bit 16 is 1, level 14 counts as pending.
- R3: While `vec_pend` is 1, `hard_req` is 1 and `sel_tt` is 9'h060, whatever the level inputs, PIL or enable are.
- R4: When no vector is pending and the pending set, read as an unsigned number, is less than (2 << `pil`), `hard_req` goes to 0 and `sel_tt` goes to 0 on the next clock.
- R5: When no vector is pending, `irq_en` is 1 and some level above `pil` is pending, the highest such level L is chosen. On the next clock `hard_req` is 1 and `sel_tt` is 9'h040 | L.
- R6: When `trap_lvl` is non-zero, `cur_tt[8:4]` equals 5'h04 and `cur_tt` is greater than the candidate trap type from R5, the outputs keep their previous values.
- R7: When no vector is pending and `irq_en` is 0, `hard_req` and `sel_tt` go to 0 on the next clock.
- R8: On a 0-to-1 change of `vec_req`, `vec_pend` becomes 1 on the next clock. At the same time `vec_word0` becomes (5'h1F << 6) | `vec_src`, and `vec_word1` and `vec_word2` become 0. The words do not change while `vec_req` stays high.
- R9: On a 1-to-0 change of `vec_req` while `vec_pend` is 1, `vec_pend`, `hard_req` and `sel_tt` all become 0 for that clock. Level arbitration resumes on the following clock.
- R10: After reset every output is 0. All outputs change exactly one clock after the inputs that cause the change. `hard_req` is 1 exactly when `sel_tt` is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_level | input | 16 | External interrupt levels, bit n = level n |
| softint | input | 17 | Software-interrupt register; bit 0 tick match, bit 16 system-tick match |
| pil | input | 4 | Processor interrupt level |
| irq_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| cur_tt | input | 9 | Trap type of the trap being handled |
| vec_req | input | 1 | Interrupt-vector request line |
| vec_src | input | 5 | Vector source number |
| hard_req | output | 1 | Hard-interrupt request |
| sel_tt | output | 9 | Selected trap type |
| vec_pend | output | 1 | Vector-pending status |
| vec_word0 | output | 64 | Vector data word 0 |
| vec_word1 | output | 64 | Vector data word 1 |
| vec_word2 | output | 64 | Vector data word 2 |

## Verification
The assertions check several things on every cycle. The vector trap type holds the request whenever the vector status is set, and the request tracks a non-zero trap type. A level-sourced trap type always lies in the external range. Disabling interrupts removes the request, a rising vector request latches the right data word, and a falling one releases everything. The bench's scenarios are needed for the rest: choosing the highest level above PIL, folding the timer bits into level 14, masking those bits out of the software vector, the exact threshold edge, and the suppression rule, whose outcome depends on the candidate compared with the trap type in service.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
   localparam int TT_W = 9;
   typedef logic [TT_W-1:0] tt_t;
   localparam tt_t EXT_BASE  = 9'h040;
   localparam tt_t VEC_TT    = 9'h060;
   localparam logic [4:0] VEC_TAG = 5'h1F;
   localparam int SRC_FIELD = 6;
endpackage

// File: rtl/irq_pend_merge.sv
`timescale 1ns/1ps
module irq_pend_merge #(
   parameter int NLVL      = 16,
   parameter int SOFT_W    = 17,
   parameter int TICK_BIT  = 0,
   parameter int STICK_BIT = 16,
   parameter int TIMER_LVL = 14
) (
   input  logic [NLVL-1:0]   ext_level,
   input  logic [SOFT_W-1:0] softint,
   output logic [NLVL-1:0]   pend
);
   logic              timer_hit;
   logic [SOFT_W-1:0] keep_mask;
   logic [SOFT_W-1:0] soft_eff;

   if (SOFT_W < NLVL) begin : g_bad_soft
      $error("irq_pend_merge: SOFT_W must cover all levels");
   end
   if (TIMER_LVL >= NLVL) begin : g_bad_tlvl
      $error("irq_pend_merge: TIMER_LVL out of range");
   end

   always_comb begin
      keep_mask            = '1;
      keep_mask[TICK_BIT]  = 1'b0;
      keep_mask[STICK_BIT] = 1'b0;
   end

   assign soft_eff  = softint & keep_mask;
   assign timer_hit = softint[TICK_BIT] | softint[STICK_BIT];

   for (genvar g = 0; g < NLVL; g++) begin : g_lvl
      if (g == TIMER_LVL) begin : g_timer
         assign pend[g] = ext_level[g] | soft_eff[g] | timer_hit;
      end else begin : g_plain
         assign pend[g] = ext_level[g] | soft_eff[g];
      end
   end
endmodule

// File: rtl/irq_level_pick.sv
`timescale 1ns/1ps
module irq_level_pick
   import irq_arb_pkg::*;
#(
   parameter int NLVL  = 16,
   parameter int PIL_W = 4,
   parameter int TL_W  = 3
) (
   input  logic [NLVL-1:0]  pend,
   input  logic [PIL_W-1:0] pil,
   input  logic [TL_W-1:0]  trap_lvl,
   input  logic [TT_W-1:0]  cur_tt,
   output logic             above,
   output logic [TT_W-1:0]  cand_tt,
   output logic             suppress
);
   localparam int CMP_W = NLVL + 1;

   logic [CMP_W-1:0] threshold;
   logic [PIL_W-1:0] top_idx;
   logic             in_ext_range;

   if (NLVL > 16) begin : g_bad_nlvl
      $error("irq_level_pick: level index must fit in the trap-type low nibble");
   end

   assign threshold = CMP_W'(2) << pil;
   assign above     = {1'b0, pend} >= threshold;

   always_comb begin
      top_idx = '0;
      for (int i = 1; i < NLVL; i++) begin
         if (pend[i]) top_idx = PIL_W'(i);
      end
   end

   assign cand_tt      = EXT_BASE | TT_W'(top_idx);
   assign in_ext_range = (cur_tt[TT_W-1:4] == EXT_BASE[TT_W-1:4]);
   assign suppress     = (trap_lvl != '0) && in_ext_range && (cur_tt > cand_tt);
endmodule

// File: rtl/irq_vec_capture.sv
`timescale 1ns/1ps
module irq_vec_capture
   import irq_arb_pkg::*;
#(
   parameter int SRC_W  = 5,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vec_req,
   input  logic [SRC_W-1:0]  vec_src,
   output logic              vec_rise,
   output logic              vec_fall,
   output logic              vec_pend,
   output logic [DATA_W-1:0] word0,
   output logic [DATA_W-1:0] word1,
   output logic [DATA_W-1:0] word2
);
   logic              req_q;
   logic [DATA_W-1:0] w0_load;

   if (SRC_W > SRC_FIELD) begin : g_bad_src
      $error("irq_vec_capture: source number wider than its field");
   end
   if (DATA_W < SRC_FIELD + 5) begin : g_bad_data
      $error("irq_vec_capture: data word too narrow for tag and source");
   end

   assign vec_rise = vec_req & ~req_q;
   assign vec_fall = ~vec_req & req_q & vec_pend;
   assign w0_load  = (DATA_W'(VEC_TAG) << SRC_FIELD) | DATA_W'(vec_src);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q    <= 1'b0;
         vec_pend <= 1'b0;
         word0    <= '0;
         word1    <= '0;
         word2    <= '0;
      end else begin
         req_q <= vec_req;
         if (vec_rise) begin
            vec_pend <= 1'b1;
            word0    <= w0_load;
            word1    <= '0;
            word2    <= '0;
         end else if (vec_fall) begin
            vec_pend <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/irq_level_arbiter.sv
`timescale 1ns/1ps
module irq_level_arbiter
   import irq_arb_pkg::*;
#(
   parameter int NLVL      = 16,
   parameter int SOFT_W    = 17,
   parameter int TICK_BIT  = 0,
   parameter int STICK_BIT = 16,
   parameter int TIMER_LVL = 14,
   parameter int TL_W      = 3,
   parameter int SRC_W     = 5,
   parameter int DATA_W    = 64,
   localparam int PIL_W    = $clog2(NLVL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLVL-1:0]   ext_level,
   input  logic [SOFT_W-1:0] softint,
   input  logic [PIL_W-1:0]  pil,
   input  logic              irq_en,
   input  logic [TL_W-1:0]   trap_lvl,
   input  logic [8:0]        cur_tt,
   input  logic              vec_req,
   input  logic [SRC_W-1:0]  vec_src,
   output logic              hard_req,
   output logic [8:0]        sel_tt,
   output logic              vec_pend,
   output logic [DATA_W-1:0] vec_word0,
   output logic [DATA_W-1:0] vec_word1,
   output logic [DATA_W-1:0] vec_word2
);
   logic [NLVL-1:0] pend;
   logic            above;
   logic            suppress;
   tt_t             cand_tt;
   logic            vec_rise;
   logic            vec_fall;
   logic            req_n;
   tt_t             tt_n;

   if (TICK_BIT >= SOFT_W || STICK_BIT >= SOFT_W) begin : g_bad_timer
      $error("irq_level_arbiter: timer bit position outside softint");
   end

   irq_pend_merge #(
      .NLVL(NLVL), .SOFT_W(SOFT_W), .TICK_BIT(TICK_BIT),
      .STICK_BIT(STICK_BIT), .TIMER_LVL(TIMER_LVL)
   ) u_merge (
      .ext_level(ext_level),
      .softint  (softint),
      .pend     (pend)
   );

   irq_level_pick #(
      .NLVL(NLVL), .PIL_W(PIL_W), .TL_W(TL_W)
   ) u_pick (
      .pend    (pend),
      .pil     (pil),
      .trap_lvl(trap_lvl),
      .cur_tt  (cur_tt),
      .above   (above),
      .cand_tt (cand_tt),
      .suppress(suppress)
   );

   irq_vec_capture #(
      .SRC_W(SRC_W), .DATA_W(DATA_W)
   ) u_vec (
      .clk     (clk),
      .rst_n   (rst_n),
      .vec_req (vec_req),
      .vec_src (vec_src),
      .vec_rise(vec_rise),
      .vec_fall(vec_fall),
      .vec_pend(vec_pend),
      .word0   (vec_word0),
      .word1   (vec_word1),
      .word2   (vec_word2)
   );

   always_comb begin
      req_n = hard_req;
      tt_n  = sel_tt;
      if (vec_rise || (vec_pend && !vec_fall)) begin
         req_n = 1'b1;
         tt_n  = VEC_TT;
      end else if (vec_fall || !above || !irq_en) begin
         req_n = 1'b0;
         tt_n  = '0;
      end else if (!suppress) begin
         req_n = 1'b1;
         tt_n  = cand_tt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hard_req <= 1'b0;
         sel_tt   <= '0;
      end else begin
         hard_req <= req_n;
         sel_tt   <= tt_n;
      end
   end
endmodule

// File: rtl/irq_level_arbiter_chk.sv
`timescale 1ns/1ps
module irq_level_arbiter_chk #(
   parameter int TL_W   = 3,
   parameter int SRC_W  = 5,
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_en,
   input logic              vec_req,
   input logic [SRC_W-1:0]  vec_src,
   input logic              hard_req,
   input logic [8:0]        sel_tt,
   input logic              vec_pend,
   input logic [DATA_W-1:0] vec_word0,
   input logic [DATA_W-1:0] vec_word1,
   input logic [DATA_W-1:0] vec_word2
);
   p_vec_owns_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vec_pend |-> (hard_req && sel_tt == 9'h060));

   p_ext_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hard_req && !vec_pend) |-> (sel_tt[8:4] == 5'h04));

   p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en && !vec_pend && !vec_req) |=> !hard_req);

   p_rise_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vec_req) |=> (vec_pend &&
         vec_word0 == ((DATA_W'(5'h1F) << 6) | DATA_W'($past(vec_src)))));

   p_words_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vec_pend |-> (vec_word1 == '0 && vec_word2 == '0));

   p_fall_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(vec_req) && vec_pend) |=> (!vec_pend && !hard_req && sel_tt == 9'h000));

   p_req_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hard_req == (sel_tt != 9'h000));
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
   .TL_W(TL_W), .SRC_W(SRC_W), .DATA_W(DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_en   (irq_en),
   .vec_req  (vec_req),
   .vec_src  (vec_src),
   .hard_req (hard_req),
   .sel_tt   (sel_tt),
   .vec_pend (vec_pend),
   .vec_word0(vec_word0),
   .vec_word1(vec_word1),
   .vec_word2(vec_word2)
);

// File: tb/irq_level_arbiter_bench.sv
`timescale 1ns/1ps
module irq_level_arbiter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ext_level = '0;
   logic [16:0] softint = '0;
   logic [3:0]  pil = '0;
   logic        irq_en = 1'b0;
   logic [2:0]  trap_lvl = '0;
   logic [8:0]  cur_tt = '0;
   logic        vec_req = 1'b0;
   logic [4:0]  vec_src = '0;
   logic        hard_req;
   logic [8:0]  sel_tt;
   logic        vec_pend;
   logic [63:0] vec_word0, vec_word1, vec_word2;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;

   typedef struct {
      int          due;
      string       tag;
      logic        req;
      logic [8:0]  tt;
      logic        vp;
      logic [63:0] w0, w1, w2;
   } exp_t;
   exp_t sb[$];

   // bench model state
   logic        m_req = 0, m_vp = 0, m_vq = 0;
   logic [8:0]  m_tt = '0;
   logic [63:0] m_w0 = '0, m_w1 = '0, m_w2 = '0;

   irq_level_arbiter u_irq_level_arbiter (
      .clk(clk), .rst_n(rst_n), .ext_level(ext_level), .softint(softint),
      .pil(pil), .irq_en(irq_en), .trap_lvl(trap_lvl), .cur_tt(cur_tt),
      .vec_req(vec_req), .vec_src(vec_src), .hard_req(hard_req),
      .sel_tt(sel_tt), .vec_pend(vec_pend), .vec_word0(vec_word0),
      .vec_word1(vec_word1), .vec_word2(vec_word2)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // compute expected outputs from the requirements and queue them
   task automatic drive(input logic [15:0] e, input logic [16:0] s,
                        input logic [3:0] p, input logic en,
                        input logic [2:0] tl, input logic [8:0] ct,
                        input logic vr, input logic [4:0] vs, input string tag);
      exp_t x;
      logic [15:0] pset;
      logic rise, fall;
      logic [8:0] cand;
      @(negedge clk);
      ext_level = e; softint = s; pil = p; irq_en = en;
      trap_lvl = tl; cur_tt = ct; vec_req = vr; vec_src = vs;
      rise = vr && !m_vq;
      fall = !vr && m_vq && m_vp;
      if (rise) begin
         m_vp = 1; m_w0 = (64'h1F << 6) | 64'(vs); m_w1 = 0; m_w2 = 0;
      end else if (fall) m_vp = 0;
      m_vq = vr;
      pset = e | (s[15:0] & 16'hFFFE);               // R1
      if (s[0] || s[16]) pset[14] = 1'b1;            // R2
      cand = 9'h040;
      for (int i = 1; i < 16; i++) if (pset[i]) cand = 9'h040 | 9'(i);
      if (m_vp) begin m_req = 1; m_tt = 9'h060; end  // R3
      else if (fall) begin m_req = 0; m_tt = 0; end   // R9
      else if ({1'b0, pset} < (17'd2 << p)) begin m_req = 0; m_tt = 0; end // R4
      else if (en) begin
         if (!(tl != 0 && ct[8:4] == 5'h04 && ct > cand)) begin // R6
            m_req = 1; m_tt = cand;                   // R5
         end
      end else begin m_req = 0; m_tt = 0; end         // R7
      x.due = cyc + 1; x.tag = tag; x.req = m_req; x.tt = m_tt; x.vp = m_vp;
      x.w0 = m_w0; x.w1 = m_w1; x.w2 = m_w2;
      sb.push_back(x);
   endtask

   // monitor: compare once the design has had its clock edge
   always @(negedge clk) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
         exp_t x;
         x = sb.pop_front();
         checks++;
         if (hard_req !== x.req || sel_tt !== x.tt || vec_pend !== x.vp ||
             vec_word0 !== x.w0 || vec_word1 !== x.w1 || vec_word2 !== x.w2) begin
            fails++;
            $display("FAIL %s: actual req=%0d tt=%h vp=%0d w0=%h w1=%h w2=%h expected req=%0d tt=%h vp=%0d w0=%h w1=%h w2=%h",
                     x.tag, hard_req, sel_tt, vec_pend, vec_word0, vec_word1, vec_word2,
                     x.req, x.tt, x.vp, x.w0, x.w1, x.w2);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;                                        // R10 reset state
      if (hard_req !== 0 || sel_tt !== 0 || vec_pend !== 0 || vec_word0 !== 0) begin
         fails++;
         $display("FAIL R10 reset: actual req=%0d tt=%h vp=%0d w0=%h expected all zero",
                  hard_req, sel_tt, vec_pend, vec_word0);
      end
      drive(16'h0008, 0, 0, 1, 0, 0, 0, 0, "R5 single level 3");
      drive(16'h0208, 0, 0, 1, 0, 0, 0, 0, "R5 highest of 3 and 9");
      drive(16'h0208, 0, 0, 1, 0, 0, 0, 0, "R10 unchanged inputs hold");
      drive(16'h0000, 17'h00020, 3, 1, 0, 0, 0, 0, "R1 software bit 5 above pil 3");
      drive(16'h0000, 17'h00001, 0, 1, 0, 0, 0, 0, "R2 tick match to level 14");
      drive(16'h0000, 17'h10000, 0, 1, 0, 0, 0, 0, "R2 system tick match to level 14");
      drive(16'h0000, 17'h00001, 14, 1, 0, 0, 0, 0, "R1 tick bit not level 0 at pil 14");
      drive(16'h0008, 0, 3, 1, 0, 0, 0, 0, "R4 level equal to pil");
      drive(16'h0010, 0, 3, 1, 0, 0, 0, 0, "R4 boundary level pil+1");
      drive(16'h8000, 0, 14, 1, 0, 0, 0, 0, "R5 level 15 over pil 14");
      drive(16'h8000, 0, 14, 0, 0, 0, 0, 0, "R7 disabled clears");
      drive(16'h0020, 0, 0, 1, 0, 0, 0, 0, "R5 level 5 before suppression");
      drive(16'h0080, 0, 0, 1, 1, 9'h048, 0, 0, "R6 level 7 under trap 0x48 held");
      drive(16'h0200, 0, 0, 1, 1, 9'h048, 0, 0, "R6 level 9 above trap 0x48 taken");
      drive(16'h0080, 0, 0, 1, 0, 9'h048, 0, 0, "R6 trap level 0 not suppressing");
      drive(16'h0020, 0, 0, 1, 2, 9'h068, 0, 0, "R6 trap outside ext range");
      drive(16'h8000, 0, 0, 1, 0, 0, 1, 5'h0B, "R8 vector rise");
      drive(16'h8000, 0, 0, 0, 0, 0, 1, 5'h15, "R3 vector owns request, R8 words kept");
      drive(16'h0000, 0, 0, 1, 0, 0, 1, 5'h15, "R3 vector with no levels");
      drive(16'h8000, 0, 0, 1, 0, 0, 0, 0, "R9 vector fall drops");
      drive(16'h8000, 0, 0, 1, 0, 0, 0, 0, "R9 levels resume");
      drive(16'h0000, 0, 0, 1, 0, 0, 1, 5'h1F, "R8 second vector rise");
      drive(16'h0000, 0, 0, 1, 0, 0, 0, 0, "R9 second fall");
      drive(16'h0000, 0, 0, 1, 0, 0, 0, 0, "R4 nothing pending");
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule